// File: doc/BRIEF.md
# Handshaked Burst Transfer Generator

This block drives one side of a small three-signal transfer: a valid strobe, a data word and an acknowledge. When a start request is sampled while the block is idle, it captures the input word and a requested burst length. It then raises the valid strobe for that many consecutive clocks, holding the captured word steady the whole time. The length is forced into the range 2 to 4.

The acknowledge is high during the final data phase of each burst, so the valid strobe drops on the clock after the acknowledge rises. A busy flag covers the whole burst and one recovery clock after it. Start requests that arrive while busy is high are ignored.

Top module: `burst_xfer_gen`

## Requirements
- R1: Every burst holds xfer_valid_o high for N consecutive clocks, never fewer than 2 nor more than 4. N is the length sampled together with the accepted start.
- R2: The 3-bit unsigned requested length is clamped. Values 0 and 1 give N=2, values 2, 3 and 4 give N equal to the value, and values 5 to 7 give N=4.
- R3: xfer_data_o equals the data_i value sampled with the accepted start, and it does not change on any clock of the burst, even if data_i changes.
- R4: While reset (synchronous, active high) is applied and just after it is released, xfer_valid_o, xfer_ack_o and busy_o are 0 and xfer_data_o is all zeros, with no unknown bits.
- R5: xfer_ack_o is high for exactly one clock per burst, and that clock is the last one in which xfer_valid_o is high. It is never high in the first valid clock, and xfer_valid_o is low on the clock after it rises.
- R6: xfer_ack_o is low in every clock where xfer_valid_o is low.
- R7: busy_o is high in every valid clock and in the one clock after xfer_valid_o falls, and low in the clock after that. A start seen while busy_o is high starts no burst.
- R8: A start sampled while busy_o is low makes xfer_valid_o high on the next clock. Between two bursts xfer_valid_o stays low for at least two clocks, and for exactly two when start is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request, sampled when idle |
| len_i | input | LEN_W (3) | Requested burst length, clamped to 2..4 |
| data_i | input | DATA_W (16) | Word to be carried by the burst |
| xfer_valid_o | output | 1 | Valid strobe |
| xfer_data_o | output | DATA_W (16) | Registered data word |
| xfer_ack_o | output | 1 | Last-phase acknowledge pulse |
| busy_o | output | 1 | Burst in progress or recovery clock |

## Verification
The bench drives every length code, including the out-of-range values 0, 1, 5 and 7. A design with a broken clamp would produce one-beat or over-long bursts, and these show up as a beat-count mismatch in the scoreboard. It changes data_i and pulses start in the middle of a burst: a design that tracked data_i or re-armed on a busy start would show a changing word or an extra, unexpected burst. It also holds start high across several bursts, so that a design missing the recovery clock, or placing the acknowledge one beat early, yields a one-clock gap or an acknowledge away from the final beat.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_GAP  = 2'd2
    } burst_state_e;

    typedef struct packed {
        logic valid;
        logic ack;
    } beat_ctl_t;

    function automatic int unsigned clamp_len(int unsigned req,
                                              int unsigned lo,
                                              int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/burst_len_sel.sv
module burst_len_sel #(
    parameter int LEN_W   = 3,
    parameter int CNT_W   = 3,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 4
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] len_o
);
    import burst_pkg::*;

    always_comb begin
        len_o = CNT_W'(clamp_len(int'(unsigned'(len_i)), MIN_LEN, MAX_LEN));
    end

endmodule

// File: rtl/burst_word_hold.sv
module burst_word_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= d_i;
        end
    end

    assign q_o = word_q;

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int CNT_W   = 3,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     len_i,
    output logic                 accept_o,
    output burst_pkg::beat_ctl_t ctl_o,
    output logic                 busy_o
);
    import burst_pkg::*;

    burst_state_e     state_q;
    beat_ctl_t        ctl_q;
    logic [CNT_W-1:0] left_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_BEAT;
                        ctl_q.valid <= 1'b1;
                        ctl_q.ack   <= 1'b0;
                        left_q    <= len_i - CNT_W'(1);
                    end
                end
                ST_BEAT: begin
                    if (left_q == '0) begin
                        state_q <= ST_GAP;
                        ctl_q   <= '0;
                    end else begin
                        left_q    <= left_q - CNT_W'(1);
                        ctl_q.ack <= (left_q == CNT_W'(1));
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign ctl_o  = ctl_q;
    assign busy_o = (state_q != ST_IDLE);

    // Checker: length of the current run of valid clocks
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)              run_q <= '0;
        else if (ctl_q.valid) run_q <= run_q + (CNT_W+1)'(1);
        else                  run_q <= '0;
    end

    a_r1_max_run: assert property (@(posedge clk) disable iff (rst)
        ctl_q.valid |-> (run_q < (CNT_W+1)'(MAX_LEN)));
    a_r1_min_run: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.valid) |-> (run_q >= (CNT_W+1)'(MIN_LEN)));
    a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.ack) |=> !ctl_q.valid);
    a_r5_no_ack_first: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.valid) |-> !ctl_q.ack);
    a_r6_ack_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.valid |-> !ctl_q.ack);
    a_r7_busy_recovery: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.valid) |-> busy_o);
    a_r7_busy_in_burst: assert property (@(posedge clk) disable iff (rst)
        ctl_q.valid |-> busy_o);
    a_r8_gap_two: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.valid) |=> !ctl_q.valid);

endmodule

// File: rtl/burst_xfer_gen.sv
module burst_xfer_gen #(
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 3,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              xfer_valid_o,
    output logic [DATA_W-1:0] xfer_data_o,
    output logic              xfer_ack_o,
    output logic              busy_o
);
    import burst_pkg::*;

    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] len_clamped;
    logic             accept;
    beat_ctl_t        ctl;

    burst_len_sel #(
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_len (
        .len_i(len_i),
        .len_o(len_clamped)
    );

    burst_seq #(
        .CNT_W  (CNT_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .len_i   (len_clamped),
        .accept_o(accept),
        .ctl_o   (ctl),
        .busy_o  (busy_o)
    );

    burst_word_hold #(
        .DATA_W(DATA_W)
    ) u_word (
        .clk   (clk),
        .rst   (rst),
        .load_i(accept),
        .d_i   (data_i),
        .q_o   (xfer_data_o)
    );

    assign xfer_valid_o = ctl.valid;
    assign xfer_ack_o   = ctl.ack;

    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        xfer_valid_o |=> (!xfer_valid_o || $stable(xfer_data_o)));
    a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !xfer_valid_o) |=> !xfer_valid_o);

endmodule

// File: tb/burst_xfer_gen_tb.sv
`timescale 1ns/1ps
module burst_xfer_gen_tb;

    typedef struct {
        int          len;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  len_i = '0;
    logic [15:0] data_i = '0;
    logic        xfer_valid_o, xfer_ack_o, busy_o;
    logic [15:0] xfer_data_o;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    int gaps[$];
    int rises = 0;
    int ends  = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    burst_xfer_gen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .data_i(data_i),
        .xfer_valid_o(xfer_valid_o), .xfer_data_o(xfer_data_o),
        .xfer_ack_o(xfer_ack_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int l);
        if (l < 2) return 2;
        if (l > 4) return 4;
        return l;
    endfunction

    // Monitor / scoreboard
    initial begin
        bit          in_b = 0;
        int          beats = 0, ack_cnt = 0, ack_pos = 0, low_run = 0;
        bit          moved = 0;
        logic [15:0] first = '0;
        exp_t        e;
        forever begin
            @(posedge clk); #1;
            if (rst) continue;
            if (xfer_valid_o) begin
                if (!in_b) begin
                    in_b = 1; beats = 0; ack_cnt = 0; ack_pos = 0; moved = 0;
                    first = xfer_data_o;
                    if (ends > 0) begin
                        gaps.push_back(low_run);
                        chk(low_run >= 2, "R8 idle clocks between bursts", low_run, 2);
                    end
                    rises++;
                end
                beats++;
                if (xfer_data_o !== first) moved = 1;
                if (xfer_ack_o) begin ack_cnt++; ack_pos = beats; end
                if (!busy_o) chk(0, "R7 busy low during burst", 0, 1);
            end else begin
                if (xfer_ack_o) chk(0, "R6 ack while valid low", 1, 0);
                if (in_b) begin
                    in_b = 0; ends++; low_run = 1;
                    chk(busy_o === 1'b1, "R7 busy in recovery clock", busy_o, 1);
                    if (sb.size() == 0) begin
                        chk(0, "R7 unexpected burst", beats, 0);
                    end else begin
                        e = sb.pop_front();
                        chk(beats == e.len, "R1/R2 burst length", beats, e.len);
                        chk(first == e.data && !moved, "R3 data word held",
                            int'(first), int'(e.data));
                        chk(ack_cnt == 1 && ack_pos == beats, "R5 ack on last beat",
                            ack_pos, beats);
                    end
                end else begin
                    low_run++;
                    if (low_run == 2 && ends > 0)
                        chk(busy_o === 1'b0, "R7 busy drops after recovery", busy_o, 0);
                end
            end
        end
    end

    task automatic launch(input int l, input logic [15:0] d);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; len_i = 3'(l); data_i = d;
        e.len = exp_len(l); e.data = d;
        sb.push_back(e);
        @(posedge clk); #1;
        chk(xfer_valid_o === 1'b1, "R8 valid one clock after start", xfer_valid_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        data_i = ~d;
    endtask

    task automatic drain();
        int n = 0;
        while ((sb.size() != 0 || busy_o) && n < 100) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        int r0, e0;
        repeat (3) @(negedge clk);
        chk(xfer_valid_o === 1'b0 && xfer_ack_o === 1'b0 && busy_o === 1'b0,
            "R4 outputs low in reset", int'(xfer_valid_o), 0);
        chk(xfer_data_o === 16'h0, "R4 data cleared in reset", int'(xfer_data_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(xfer_valid_o === 1'b0 && busy_o === 1'b0 && xfer_data_o === 16'h0,
            "R4 idle after reset", int'(xfer_valid_o), 0);

        // R1/R2: each length code, including clamped ones
        for (int l = 0; l < 8; l++) begin
            launch(l, 16'hA500 + 16'(l));
            drain();
        end
        launch(3, 16'h1234); launch(2, 16'hFFFF); launch(4, 16'h0001);
        drain();

        // R7: start and data change during a burst are ignored
        e0 = ends;
        launch(4, 16'hBEEF);
        start_i = 1'b1; len_i = 3'd2; data_i = 16'h0F0F;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        drain();
        chk(ends == e0 + 1, "R7 start while busy ignored", ends - e0, 1);
        chk(xfer_data_o == 16'hBEEF, "R3 word kept after ignored start",
            int'(xfer_data_o), 16'hBEEF);

        // R8: start held high gives exactly two idle clocks
        gaps.delete();
        r0 = rises;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            exp_t e; e.len = 3; e.data = 16'h5A5A; sb.push_back(e);
        end
        start_i = 1'b1; len_i = 3'd3; data_i = 16'h5A5A;
        while (rises < r0 + 3) @(negedge clk);
        start_i = 1'b0;
        drain();
        chk(gaps.size() >= 3, "R8 gap log size", gaps.size(), 3);
        if (gaps.size() >= 3) begin
            chk(gaps[1] == 2, "R8 held start gap", gaps[1], 2);
            chk(gaps[2] == 2, "R8 held start gap", gaps[2], 2);
        end
        chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
        report();
    end

endmodule